// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Decoder

This block sits in the memory request path and watches each incoming memory read or write. A single control word, loaded through a separate legacy configuration write port, holds an enable bit, a window size code and a window base below 4 GB. When the decoder is enabled and a request's address lands inside the window, the request is turned into a configuration request. The address is split into bus, device, function, a 4-bit extended register number and an 8-bit register number. Every other request goes unchanged to the ordinary memory path.

The window can be 256 MB, 128 MB or 64 MB. A smaller window reaches fewer buses, and the base is always aligned to the window size. The request side uses a valid/ready handshake. The decoder is purely combinational between the request port and its two output ports, so no request is held inside the block. In the cycle when the control word is being written, the decoder accepts no request, so no request is ever decoded against a half-written control word.

Top module: `cfgWinDecoder`

## Requirements
- R1: After reset the control word reads back as 0, so the decoder is disabled.
- R2: While the enable bit (bit 0 of the control word) is 0, every memory request goes to the pass-through port with its address, write flag, byte enables and data unchanged, and `cfgValid` stays 0.
- R3: A legacy write loads the control word so that it reads back on the next clock. Enable is bit 0, the size code is bits 2:1 and the base is bits 31:26. Base bits below the window size read back as zero, and so do bits 25:3.
- R4: A request hits when the decoder is enabled, the address bits above bit 31 are all zero, and the address bits from bit N up to bit 31 equal the base. N is 28 for size code 0 (256 MB), 27 for code 1 (128 MB) and 26 for code 2 (64 MB).
- R5: Size code 3 behaves exactly like size code 0: a 256 MB window with 256 buses.
- R6: On a hit the emitted fields are: bus = address bits 27:20, device = 19:15, function = 14:12, extended register = 11:8, register = 7:0. The write flag, byte enables and write data are copied from the request.
- R7: With a 128 MB window the bus is {0, address bits 26:20}. With a 64 MB window it is {00, address bits 25:20}.
- R8: An address at or above 4 GB never hits and goes to the pass-through port.
- R9: At most one of `cfgValid` and `pthValid` is set. `memReady` equals the ready of the port the request is routed to.
- R10: In a cycle where `lgcWrEn` is 1, `memReady`, `cfgValid` and `pthValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lgcWrEn | input | 1 | Legacy write strobe for the control word |
| lgcWrData | input | 32 | Legacy write data |
| winCtrlRd | output | 32 | Control word read-back |
| memValid | input | 1 | Memory request valid |
| memReady | output | 1 | Memory request accepted |
| memWrite | input | 1 | 1 = write, 0 = read |
| memAddr | input | ADDR_W | Request byte address |
| memBe | input | DATA_W/8 | Byte enables |
| memWdata | input | DATA_W | Write data |
| pthValid | output | 1 | Pass-through request valid |
| pthReady | input | 1 | Pass-through port ready |
| pthWrite | output | 1 | Pass-through write flag |
| pthAddr | output | ADDR_W | Pass-through address |
| pthBe | output | DATA_W/8 | Pass-through byte enables |
| pthWdata | output | DATA_W | Pass-through write data |
| cfgValid | output | 1 | Configuration request valid |
| cfgReady | input | 1 | Configuration port ready |
| cfgWrite | output | 1 | Configuration write flag |
| cfgBus | output | 8 | Bus number |
| cfgDev | output | 5 | Device number |
| cfgFunc | output | 3 | Function number |
| cfgExtReg | output | 4 | Extended register number |
| cfgReg | output | 8 | Register byte offset |
| cfgBe | output | DATA_W/8 | Configuration byte enables |
| cfgWdata | output | DATA_W | Configuration write data |

## Verification
The assertions assume two things about the inputs. While `memValid` is held, the address and payload stay steady. The legacy port only writes well-formed words, meaning every write's effect is checked at the read-back port one clock later. The assertions relate the routed valids, the stall during a legacy write, the bus-width limit per size and the read-back alignment. The bench drives every input on the falling edge and holds each request steady for the whole cycle. It changes the control word only through single-cycle legacy writes that do not overlap a request being checked.

// File: rtl/cfgWinPkg.sv
package cfgWinPkg;
  localparam int BASE_LSB = 26;
  localparam int BASE_W   = 32 - BASE_LSB;
  localparam int BUS_W    = 8;

  typedef struct packed {
    logic             selCfg;
    logic             fwdCfg;
    logic             fwdPth;
    logic             stall;
    logic [BUS_W-1:0] busMask;
  } ctlStrobes_t;
endpackage

// File: rtl/cfgWinCtrl.sv
module cfgWinCtrl
  import cfgWinPkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lgcWrEn,
  input  logic                     wrEnBit,
  input  logic [1:0]               wrSize,
  input  logic [BASE_W-1:0]        wrBase,
  input  logic                     memValid,
  input  logic [ADDR_W-1:BASE_LSB] addrHi,
  output ctlStrobes_t              strb,
  output logic [31:0]              winCtrlRd
);
  localparam int HI_W = ADDR_W - 32;

  logic              winEn;
  logic [1:0]        sizeSel;
  logic [BASE_W-1:0] baseHi;
  logic              hit;

  function automatic logic [BASE_W-1:0] baseMaskOf(input logic [1:0] sz);
    case (sz)
      2'd1:    baseMaskOf = {{(BASE_W-1){1'b1}}, 1'b0};
      2'd2:    baseMaskOf = {BASE_W{1'b1}};
      default: baseMaskOf = {{(BASE_W-2){1'b1}}, 2'b00};
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] busMaskOf(input logic [1:0] sz);
    case (sz)
      2'd1:    busMaskOf = {1'b0, {(BUS_W-1){1'b1}}};
      2'd2:    busMaskOf = {2'b00, {(BUS_W-2){1'b1}}};
      default: busMaskOf = {BUS_W{1'b1}};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winEn   <= 1'b0;
      sizeSel <= 2'd0;
      baseHi  <= '0;
    end else if (lgcWrEn) begin
      winEn   <= wrEnBit;
      sizeSel <= wrSize;
      baseHi  <= wrBase & baseMaskOf(wrSize);
    end
  end

  always_comb begin
    hit = winEn
       && (addrHi[ADDR_W-1:32] == {HI_W{1'b0}})
       && ((addrHi[31:BASE_LSB] & baseMaskOf(sizeSel)) == baseHi);
    strb.selCfg  = hit;
    strb.stall   = lgcWrEn;
    strb.fwdCfg  = memValid && hit && !lgcWrEn;
    strb.fwdPth  = memValid && !hit && !lgcWrEn;
    strb.busMask = busMaskOf(sizeSel);
    winCtrlRd    = {baseHi, {(BASE_LSB-3){1'b0}}, sizeSel, winEn};
  end
endmodule

// File: rtl/cfgWinDatapath.sv
module cfgWinDatapath
  import cfgWinPkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32
) (
  input  ctlStrobes_t         strb,
  input  logic                memWrite,
  input  logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W/8-1:0] memBe,
  input  logic [DATA_W-1:0]   memWdata,
  output logic                memReady,
  output logic                pthValid,
  input  logic                pthReady,
  output logic                pthWrite,
  output logic [ADDR_W-1:0]   pthAddr,
  output logic [DATA_W/8-1:0] pthBe,
  output logic [DATA_W-1:0]   pthWdata,
  output logic                cfgValid,
  input  logic                cfgReady,
  output logic                cfgWrite,
  output logic [BUS_W-1:0]    cfgBus,
  output logic [4:0]          cfgDev,
  output logic [2:0]          cfgFunc,
  output logic [3:0]          cfgExtReg,
  output logic [7:0]          cfgReg,
  output logic [DATA_W/8-1:0] cfgBe,
  output logic [DATA_W-1:0]   cfgWdata
);
  always_comb begin
    memReady  = !strb.stall && (strb.selCfg ? cfgReady : pthReady);
    pthValid  = strb.fwdPth;
    pthWrite  = memWrite;
    pthAddr   = memAddr;
    pthBe     = memBe;
    pthWdata  = memWdata;
    cfgValid  = strb.fwdCfg;
    cfgWrite  = memWrite;
    cfgBus    = memAddr[27:20] & strb.busMask;
    cfgDev    = memAddr[19:15];
    cfgFunc   = memAddr[14:12];
    cfgExtReg = memAddr[11:8];
    cfgReg    = memAddr[7:0];
    cfgBe     = memBe;
    cfgWdata  = memWdata;
  end
endmodule

// File: rtl/cfgWinDecoder.sv
module cfgWinDecoder
  import cfgWinPkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lgcWrEn,
  input  logic [31:0]         lgcWrData,
  output logic [31:0]         winCtrlRd,
  input  logic                memValid,
  output logic                memReady,
  input  logic                memWrite,
  input  logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W/8-1:0] memBe,
  input  logic [DATA_W-1:0]   memWdata,
  output logic                pthValid,
  input  logic                pthReady,
  output logic                pthWrite,
  output logic [ADDR_W-1:0]   pthAddr,
  output logic [DATA_W/8-1:0] pthBe,
  output logic [DATA_W-1:0]   pthWdata,
  output logic                cfgValid,
  input  logic                cfgReady,
  output logic                cfgWrite,
  output logic [7:0]          cfgBus,
  output logic [4:0]          cfgDev,
  output logic [2:0]          cfgFunc,
  output logic [3:0]          cfgExtReg,
  output logic [7:0]          cfgReg,
  output logic [DATA_W/8-1:0] cfgBe,
  output logic [DATA_W-1:0]   cfgWdata
);
  ctlStrobes_t strb;

  cfgWinCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .lgcWrEn(lgcWrEn),
    .wrEnBit(lgcWrData[0]), .wrSize(lgcWrData[2:1]),
    .wrBase(lgcWrData[31:BASE_LSB]),
    .memValid(memValid), .addrHi(memAddr[ADDR_W-1:BASE_LSB]),
    .strb(strb), .winCtrlRd(winCtrlRd)
  );

  cfgWinDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .strb(strb), .memWrite(memWrite), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memReady(memReady),
    .pthValid(pthValid), .pthReady(pthReady), .pthWrite(pthWrite),
    .pthAddr(pthAddr), .pthBe(pthBe), .pthWdata(pthWdata),
    .cfgValid(cfgValid), .cfgReady(cfgReady), .cfgWrite(cfgWrite),
    .cfgBus(cfgBus), .cfgDev(cfgDev), .cfgFunc(cfgFunc),
    .cfgExtReg(cfgExtReg), .cfgReg(cfgReg), .cfgBe(cfgBe), .cfgWdata(cfgWdata)
  );
endmodule

// File: rtl/cfgWinChecker.sv
module cfgWinChecker #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              lgcWrEn,
  input logic [31:0]       lgcWrData,
  input logic [31:0]       winCtrlRd,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pthValid,
  input logic              cfgValid,
  input logic [7:0]        cfgBus
);
  p_one_route_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgValid && pthValid));

  p_valid_needs_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid || pthValid) |-> memValid);

  p_off_no_cfg_r2: assert property (@(posedge clk) disable iff (!rstN)
    !winCtrlRd[0] |-> !cfgValid);

  p_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    lgcWrEn |-> (!memReady && !cfgValid && !pthValid));

  p_low4g_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (memAddr[ADDR_W-1:32] == '0));

  p_bus64_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && winCtrlRd[2:1] == 2'd2) |-> (cfgBus[7:6] == 2'b00));

  p_bus128_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && winCtrlRd[2:1] == 2'd1) |-> (cfgBus[7] == 1'b0));

  p_write_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    lgcWrEn |=> (winCtrlRd[2:0] == $past(lgcWrData[2:0])));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (winCtrlRd[25:3] == '0) && (winCtrlRd[2:1] == 2'd2 || winCtrlRd[26] == 1'b0));
endmodule

bind cfgWinDecoder cfgWinChecker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .lgcWrEn(lgcWrEn), .lgcWrData(lgcWrData),
  .winCtrlRd(winCtrlRd), .memValid(memValid), .memReady(memReady),
  .memAddr(memAddr), .pthValid(pthValid), .cfgValid(cfgValid), .cfgBus(cfgBus)
);

// File: tb/cfgWinDecoder_tb_top.sv
module cfgWinDecoder_tb_top;
  localparam int ADDR_W = 40;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lgcWrEn = 1'b0;
  logic [31:0] lgcWrData = '0;
  logic [31:0] winCtrlRd;
  logic memValid = 1'b0, memWrite = 1'b0;
  logic memReady;
  logic [ADDR_W-1:0] memAddr = '0;
  logic [3:0] memBe = '0;
  logic [31:0] memWdata = '0;
  logic pthValid, pthWrite, pthReady = 1'b1;
  logic [ADDR_W-1:0] pthAddr;
  logic [3:0] pthBe, cfgBe;
  logic [31:0] pthWdata, cfgWdata;
  logic cfgValid, cfgWrite, cfgReady = 1'b1;
  logic [7:0] cfgBus, cfgReg;
  logic [4:0] cfgDev;
  logic [2:0] cfgFunc;
  logic [3:0] cfgExtReg;

  int total = 0;
  int bad = 0;
  logic mEn = 1'b0;
  logic [1:0] mSize = 2'd0;
  logic [31:0] mBase = '0;

  always #2 clk = ~clk;

  cfgWinDecoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lsbOf(input logic [1:0] sz);
    return (sz == 2'd1) ? 27 : (sz == 2'd2) ? 26 : 28;
  endfunction

  task automatic prog(input logic en, input logic [1:0] sz, input logic [31:0] base,
                      input logic [ADDR_W-1:0] probe);
    logic [31:0] expRd;
    @(negedge clk);
    lgcWrEn = 1'b1;
    lgcWrData = base | {29'd0, sz, en};
    memValid = 1'b1; memAddr = probe;
    #1;
    chk(!memReady && !cfgValid && !pthValid, "R10 stall", {memReady, cfgValid, pthValid}, 0);
    @(negedge clk);
    lgcWrEn = 1'b0; memValid = 1'b0; lgcWrData = '0;
    mEn = en; mSize = sz;
    mBase = (base >> lsbOf(sz)) << lsbOf(sz);
    expRd = {mBase[31:26], 23'd0, sz, en};
    #1;
    chk(winCtrlRd == expRd, "R3 readback", winCtrlRd, expRd);
  endtask

  task automatic doReq(input logic [ADDR_W-1:0] a, input logic wr, input string req);
    bit hit;
    logic [7:0] eBus;
    @(negedge clk);
    memValid = 1'b1; memAddr = a; memWrite = wr;
    memBe = a[3:0] ^ 4'hA; memWdata = a[31:0] ^ 32'h5A5A_1234;
    #1;
    hit = mEn && (a[ADDR_W-1:32] == '0) &&
          ((a[31:0] >> lsbOf(mSize)) == (mBase >> lsbOf(mSize)));
    if (hit) begin
      eBus = a[27:20];
      if (mSize == 2'd1) eBus[7] = 1'b0;
      if (mSize == 2'd2) eBus[7:6] = 2'b00;
      chk(cfgValid && !pthValid, {req, " hit"}, {cfgValid, pthValid}, 2);
      chk(cfgBus == eBus, {req, " bus"}, cfgBus, eBus);
      chk({cfgDev, cfgFunc, cfgExtReg, cfgReg} == a[19:0], "R6 fields",
          {cfgDev, cfgFunc, cfgExtReg, cfgReg}, a[19:0]);
      chk(cfgWrite == wr && cfgBe == memBe && cfgWdata == memWdata, "R6 payload",
          cfgWdata, memWdata);
      chk(memReady == cfgReady, "R9 ready cfg", memReady, cfgReady);
    end else begin
      chk(pthValid && !cfgValid, {req, " miss"}, {cfgValid, pthValid}, 1);
      chk(pthAddr == a && pthWrite == wr && pthBe == memBe && pthWdata == memWdata,
          "R2 passthrough", pthAddr, a);
      chk(memReady == pthReady, "R9 ready pth", memReady, pthReady);
    end
    @(negedge clk);
    memValid = 1'b0;
  endtask

  task automatic tReset();
    #1;
    chk(winCtrlRd == 32'd0, "R1 reset", winCtrlRd, 0);
    doReq(40'h00_E000_0000, 1'b0, "R1");
  endtask

  task automatic tDisabled();
    prog(1'b0, 2'd0, 32'hE000_0000, 40'h0);
    doReq(40'h00_E012_3456, 1'b1, "R2");
  endtask

  task automatic tMap256();
    prog(1'b1, 2'd0, 32'hE000_0000, 40'h00_E000_0000);
    doReq(40'h00_E051_AA4C, 1'b1, "R4");
    doReq(40'h00_EFF0_0000, 1'b0, "R6");
    doReq(40'h00_D000_0000, 1'b0, "R4");
    doReq(40'h01_E000_0000, 1'b0, "R8");
  endtask

  task automatic tAlign();
    prog(1'b1, 2'd1, 32'hECF0_0000, 40'h0);
    chk(winCtrlRd == 32'hE800_0003, "R3 align", winCtrlRd, 32'hE800_0003);
  endtask

  task automatic tBus128();
    prog(1'b1, 2'd1, 32'h8000_0000, 40'h0);
    doReq(40'h00_87F0_8123, 1'b0, "R7");
    doReq(40'h00_8800_0000, 1'b0, "R4");
  endtask

  task automatic tBus64();
    prog(1'b1, 2'd2, 32'hC400_0000, 40'h0);
    doReq(40'h00_C7FF_F0FC, 1'b1, "R7");
    doReq(40'h00_C000_0000, 1'b0, "R4");
  endtask

  task automatic tSize3();
    prog(1'b1, 2'd3, 32'hF000_0000, 40'h0);
    doReq(40'h00_FFF0_0010, 1'b0, "R5");
    doReq(40'h00_F800_0000, 1'b1, "R5");
  endtask

  task automatic tBackpressure();
    cfgReady = 1'b0; pthReady = 1'b1;
    doReq(40'h00_F123_4567, 1'b0, "R9");
    cfgReady = 1'b1; pthReady = 1'b0;
    doReq(40'h00_1000_0000, 1'b0, "R9");
    pthReady = 1'b1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        tReset();
        tDisabled();
        tMap256();
        tAlign();
        tBus128();
        tBus64();
        tSize3();
        tBackpressure();
      end
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule